// File: doc/BRIEF.md
# Single-Error-Correcting SRAM Wrapper

This block places a single-port synchronous memory behind a small request interface and protects every stored word with a SECDED code. The code corrects one flipped bit and detects two. Check bits are computed before a word is written. Each word read from the array is decoded, and a single-bit fault is repaired on the way out.

A write that covers every byte is encoded and stored in the cycle it is requested. A write that covers only some bytes needs the old contents. The block reads the stored word, corrects it, and puts the new bytes over it. In the following cycle it encodes the result and stores it. During that second cycle the grant is low, so any request presented then waits. Two outputs pulse for one cycle each. One marks an access whose stored word had a corrected fault. The other marks an access whose stored word had an uncorrectable fault.

Top module: `secded_sram`

## Requirements
- R1: A granted read returns the stored data on `rdata_o` in the cycle right after the request was accepted.
- R2: A stored word is laid out as {check[6:0], data[31:0]}, with the check bits in positions 38..32. Data bit i is given the i-th 7-bit value of weight three, counting in ascending numeric order, as its column. Check bit j is the XOR of every data bit whose column has bit j set.
- R3: A read, or a write with all four byte enables set, is granted in the cycle it is requested, and `gnt_o` stays high in the next cycle.
- R4: A write with `be_i` not all ones stores new data in the enabled bytes and keeps the other bytes of the old word. Byte enable k covers data bits 8k+7..8k. With no enable set, the word is written back unchanged. `gnt_o` is low for exactly one cycle after such a write.
- R5: On a read, a single flipped bit in either the data or the check field is corrected in `rdata_o`, and `corr_o` pulses for one cycle.
- R6: On a read, two flipped bits raise `unc_o` for one cycle while `corr_o` stays low. The two error outputs are never high together.
- R7: If the old word of a partial write holds a single-bit fault, the fault is corrected before the merge and `corr_o` pulses in the stall cycle. A later read returns the merged word with no error pulse.
- R8: If the old word of a partial write holds a double-bit fault, `unc_o` pulses in the stall cycle. The merged word, with the unenabled bytes taken as stored, is still re-encoded and written, so a later read returns it clean.
- R9: A request presented while `gnt_o` is low has no effect on the memory.
- R10: In the cycle after reset is released, `gnt_o` is high and both error outputs are low.
- R11: Error outputs pulse only in the cycle after an accepted read or partial write. A full-word write over a corrupted word raises neither output, and a later read of that word is clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables for writes |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| gnt_o | output | 1 | Request accepted this cycle |
| rdata_o | output | 32 | Corrected read data, one cycle after a read |
| corr_o | output | 1 | One-cycle pulse: corrected single-bit fault |
| unc_o | output | 1 | One-cycle pulse: uncorrectable fault |

## Verification
The properties assume that requests are driven only while reset is low. They also assume that a request counts only when it meets a high grant, so a request held across the stall cycle is simply not taken. The stimulus drives the inputs on the falling edge and lowers `req_i` after each access. Faults are planted by overwriting stored codewords with encodings the bench computes itself and then flipping chosen bits. The bench deliberately presents one request during a stall to confirm that it is dropped.

// File: rtl/ss_pkg.sv
package ss_pkg;

  // Smallest check width k with 2^(k-1) >= data + k (SECDED bound).
  function automatic int unsigned chk_width(int unsigned dw);
    int unsigned k;
    k = 2;
    while ((1 << (k - 1)) < (dw + k)) k++;
    return k;
  endfunction

  // Column idx of the parity matrix: odd weights from 3 upward, ascending value.
  function automatic logic [31:0] hsiao_col(int unsigned cw, int unsigned idx);
    int unsigned n;
    logic [31:0] r;
    n = 0;
    r = '0;
    for (int w = 3; w <= int'(cw); w += 2) begin
      for (int v = 1; v < (1 << cw); v++) begin
        if ($countones(v) == w) begin
          if (n == idx) r = v;
          n++;
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ss_hmatrix.sv
module ss_hmatrix #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 7
) (
  output logic [CW-1:0][DW-1:0] h_o
);
  for (genvar i = 0; i < DW; i++) begin : g_col
    localparam logic [31:0] COL = ss_pkg::hsiao_col(CW, i);
    for (genvar j = 0; j < CW; j++) begin : g_row
      assign h_o[j][i] = COL[j];
    end
  end
endmodule

// File: rtl/ss_enc.sv
module ss_enc #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 7
) (
  input  logic [DW-1:0]    data_i,
  output logic [DW+CW-1:0] code_o
);
  logic [CW-1:0][DW-1:0] h;
  logic [CW-1:0]         chk;

  ss_hmatrix #(.DW(DW), .CW(CW)) u_h (.h_o(h));

  always_comb begin
    for (int j = 0; j < CW; j++) chk[j] = ^(data_i & h[j]);
  end

  assign code_o = {chk, data_i};
endmodule

// File: rtl/ss_dec.sv
module ss_dec #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 7
) (
  input  logic [DW+CW-1:0] code_i,
  output logic [DW-1:0]    data_o,
  output logic             corr_o,
  output logic             unc_o
);
  logic [CW-1:0][DW-1:0] h;
  logic [CW-1:0]         syn;
  logic [CW-1:0]         col;
  logic [DW-1:0]         flip;
  logic                  hit;

  ss_hmatrix #(.DW(DW), .CW(CW)) u_h (.h_o(h));

  always_comb begin
    for (int j = 0; j < CW; j++)
      syn[j] = (^(code_i[DW-1:0] & h[j])) ^ code_i[DW+j];
  end

  always_comb begin
    flip = '0;
    hit  = $onehot(syn);
    col  = '0;
    for (int i = 0; i < DW; i++) begin
      for (int j = 0; j < CW; j++) col[j] = h[j][i];
      if (syn == col) begin
        flip[i] = 1'b1;
        hit     = 1'b1;
      end
    end
  end

  assign data_o = code_i[DW-1:0] ^ flip;
  assign corr_o = hit;
  assign unc_o  = (syn != '0) && !hit;
endmodule

// File: rtl/ss_ram.sv
module ss_ram #(
  parameter int unsigned AW = 6,
  parameter int unsigned W  = 39
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/secded_sram.sv
module secded_sram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [DATA_W/8-1:0]   be_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  gnt_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  corr_o,
  output logic                  unc_o
);
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned CHK_W  = ss_pkg::chk_width(DATA_W);
  localparam int unsigned CODE_W = DATA_W + CHK_W;

  logic              accept, full;
  logic              rmw_q, rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] old_data, merged, enc_in;
  logic [CODE_W-1:0] enc_code, ram_rdata;
  logic              dec_corr, dec_unc;
  logic              ram_en, ram_we;
  logic [ADDR_W-1:0] ram_addr;

  assign gnt_o  = ~rmw_q;
  assign accept = req_i & gnt_o;
  assign full   = &be_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rmw_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      rmw_q <= accept & we_i & ~full;
      rd_q  <= accept & ~we_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  for (genvar k = 0; k < BE_W; k++) begin : g_merge
    assign merged[8*k +: 8] = be_q[k] ? wdata_q[8*k +: 8] : old_data[8*k +: 8];
  end

  assign enc_in   = rmw_q ? merged : wdata_i;
  assign ram_en   = rmw_q | accept;
  assign ram_we   = rmw_q | (accept & we_i & full);
  assign ram_addr = rmw_q ? addr_q : addr_i;

  ss_enc #(.DW(DATA_W), .CW(CHK_W)) u_enc (
    .data_i (enc_in),
    .code_o (enc_code)
  );

  ss_ram #(.AW(ADDR_W), .W(CODE_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (ram_en),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (enc_code),
    .rdata_o (ram_rdata)
  );

  ss_dec #(.DW(DATA_W), .CW(CHK_W)) u_dec (
    .code_i (ram_rdata),
    .data_o (old_data),
    .corr_o (dec_corr),
    .unc_o  (dec_unc)
  );

  assign rdata_o = old_data;
  assign corr_o  = dec_corr & (rd_q | rmw_q);
  assign unc_o   = dec_unc & (rd_q | rmw_q);
endmodule

// File: rtl/ss_chk.sv
module ss_chk #(
  parameter int unsigned BE_W = 4
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic            req_i,
  input logic            we_i,
  input logic [BE_W-1:0] be_i,
  input logic            gnt_o,
  input logic            corr_o,
  input logic            unc_o
);
  p_stall_after_partial_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && gnt_o && we_i && !(&be_i)) |=> !gnt_o);

  p_single_stall_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !gnt_o |=> gnt_o);

  p_no_stall_full_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && gnt_o && (!we_i || (&be_i))) |=> gnt_o);

  p_flags_exclusive_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(corr_o && unc_o));

  p_flags_need_access_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (corr_o || unc_o) |-> $past(req_i && gnt_o && !(we_i && (&be_i))));

  p_reset_state_r10: assert property (@(posedge clk_i)
    rst_i |=> (gnt_o && !corr_o && !unc_o));
endmodule

bind secded_sram ss_chk #(.BE_W(DATA_W/8)) u_ss_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .req_i  (req_i),
  .we_i   (we_i),
  .be_i   (be_i),
  .gnt_o  (gnt_o),
  .corr_o (corr_o),
  .unc_o  (unc_o)
);

// File: tb/secded_sram_bench.sv
module secded_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic        we;
    logic [3:0]  be;
    logic [5:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'hF, 6'd1, 32'hDEADBEEF, 32'h0},
    '{1'b0, 4'h0, 6'd1, 32'h0,        32'hDEADBEEF},
    '{1'b1, 4'hF, 6'd2, 32'h12345678, 32'h0},
    '{1'b1, 4'h5, 6'd2, 32'hAABBCCDD, 32'h0},
    '{1'b0, 4'h0, 6'd2, 32'h0,        32'h12BB56DD},
    '{1'b1, 4'hF, 6'd3, 32'h00000000, 32'h0},
    '{1'b1, 4'h8, 6'd3, 32'hFF000000, 32'h0},
    '{1'b0, 4'h0, 6'd3, 32'h0,        32'hFF000000},
    '{1'b1, 4'hF, 6'd0, 32'hFFFFFFFF, 32'h0},
    '{1'b1, 4'h0, 6'd0, 32'h01234567, 32'h0},
    '{1'b0, 4'h0, 6'd0, 32'h0,        32'hFFFFFFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we  = 1'b0;
  logic [3:0]  be  = 4'h0;
  logic [5:0]  addr = '0;
  logic [31:0] wd  = '0;
  logic        gnt, corr, unc;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_sram u_secded_sram (
    .clk_i(clk), .rst_i(rst), .req_i(req), .we_i(we), .be_i(be),
    .addr_i(addr), .wdata_i(wd), .gnt_o(gnt), .rdata_o(rdata),
    .corr_o(corr), .unc_o(unc)
  );

  // Check bits per R2: data bit n uses the n-th weight-3 value in ascending order.
  function automatic logic [6:0] bench_chk(logic [31:0] d);
    logic [6:0] c;
    int n;
    c = '0;
    n = 0;
    for (int v = 7; v < 128; v++) begin
      if ($countones(v) == 3 && n < 32) begin
        if (d[n]) c = c ^ v[6:0];
        n++;
      end
    end
    return c;
  endfunction

  task automatic poke(input logic [5:0] a, input logic [31:0] d, input logic [38:0] mask);
    u_secded_sram.u_ram.mem_q[a] = {bench_chk(d), d} ^ mask;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [3:0] b, input logic [5:0] a,
                    input logic [31:0] d, output logic g0, output logic [31:0] rd,
                    output logic c, output logic u, output logic g1);
    @(negedge clk);
    req = 1'b1; we = w; be = b; addr = a; wd = d;
    g0 = gnt;
    @(negedge clk);
    req = 1'b0;
    rd = rdata; c = corr; u = unc; g1 = gnt;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic g0, g1, c, u;
    logic [31:0] rd;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: state after reset
    check("R10 gnt", {31'b0, gnt}, 32'd1);
    check("R10 corr", {31'b0, corr}, 32'd0);
    check("R10 unc", {31'b0, unc}, 32'd0);

    // Vector table: R1 read data, R3/R4 grant behaviour, R11 no pulses on clean words
    for (int i = 0; i < NV; i++) begin
      op(VECS[i].we, VECS[i].be, VECS[i].addr, VECS[i].wd, g0, rd, c, u, g1);
      check("R3 grant on request", {31'b0, g0}, 32'd1);
      if (VECS[i].we) begin
        if (VECS[i].be == 4'hF) check("R3 no stall", {31'b0, g1}, 32'd1);
        else                    check("R4 stall", {31'b0, g1}, 32'd0);
      end else begin
        check("R1/R4 read data", rd, VECS[i].exp);
      end
      check("R11 no pulse clean", {30'b0, c, u}, 32'd0);
    end

    // R2: bench-encoded words read back clean
    for (int i = 0; i < 32; i += 3) begin
      poke(6'd40, (32'h1 << i) ^ 32'h5A5A0000, '0);
      op(1'b0, 4'h0, 6'd40, '0, g0, rd, c, u, g1);
      check("R2 data", rd, (32'h1 << i) ^ 32'h5A5A0000);
      check("R2 no error", {30'b0, c, u}, 32'd0);
    end

    // R5: single data-bit and check-bit faults
    poke(6'd5, 32'hCAFE1234, 39'h1 << 5);
    op(1'b0, 4'h0, 6'd5, '0, g0, rd, c, u, g1);
    check("R5 data fix", rd, 32'hCAFE1234);
    check("R5 corr pulse", {30'b0, c, u}, 32'd2);
    @(negedge clk);
    check("R5 pulse one cycle", {31'b0, corr}, 32'd0);
    poke(6'd6, 32'h0F0F00FF, 39'h1 << 35);
    op(1'b0, 4'h0, 6'd6, '0, g0, rd, c, u, g1);
    check("R5 check-bit fix", rd, 32'h0F0F00FF);
    check("R5 check-bit corr", {30'b0, c, u}, 32'd2);

    // R6: double fault
    poke(6'd7, 32'h13579BDF, (39'h1 << 0) | (39'h1 << 9));
    op(1'b0, 4'h0, 6'd7, '0, g0, rd, c, u, g1);
    check("R6 unc only", {30'b0, c, u}, 32'd1);

    // R7: partial write over single fault
    poke(6'd10, 32'h11223344, 39'h1 << 20);
    op(1'b1, 4'h1, 6'd10, 32'h000000AA, g0, rd, c, u, g1);
    check("R7 corr in stall", {30'b0, c, u}, 32'd2);
    op(1'b0, 4'h0, 6'd10, '0, g0, rd, c, u, g1);
    check("R7 merged", rd, 32'h112233AA);
    check("R7 clean after", {30'b0, c, u}, 32'd0);

    // R8: partial write over double fault in the overwritten byte
    poke(6'd11, 32'h55667788, (39'h1 << 1) | (39'h1 << 2));
    op(1'b1, 4'h1, 6'd11, 32'h00000099, g0, rd, c, u, g1);
    check("R8 unc in stall", {30'b0, c, u}, 32'd1);
    op(1'b0, 4'h0, 6'd11, '0, g0, rd, c, u, g1);
    check("R8 merged", rd, 32'h55667799);
    check("R8 clean after", {30'b0, c, u}, 32'd0);

    // R11: full write over corrupted word
    poke(6'd12, 32'h00000000, (39'h1 << 3) | (39'h1 << 30));
    op(1'b1, 4'hF, 6'd12, 32'hCAFEF00D, g0, rd, c, u, g1);
    check("R11 no pulse on full write", {30'b0, c, u}, 32'd0);
    op(1'b0, 4'h0, 6'd12, '0, g0, rd, c, u, g1);
    check("R11 data", rd, 32'hCAFEF00D);
    check("R11 clean", {30'b0, c, u}, 32'd0);

    // R9: request during stall is dropped
    op(1'b1, 4'hF, 6'd20, 32'h0BADF00D, g0, rd, c, u, g1);
    op(1'b1, 4'hF, 6'd21, 32'h01010101, g0, rd, c, u, g1);
    @(negedge clk);
    req = 1'b1; we = 1'b1; be = 4'h1; addr = 6'd20; wd = 32'h00000077;
    @(negedge clk);
    check("R9 gnt low in stall", {31'b0, gnt}, 32'd0);
    be = 4'hF; addr = 6'd21; wd = 32'hFFFFFFFF;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    op(1'b0, 4'h0, 6'd21, '0, g0, rd, c, u, g1);
    check("R9 stalled write dropped", rd, 32'h01010101);
    op(1'b0, 4'h0, 6'd20, '0, g0, rd, c, u, g1);
    check("R4 partial result", rd, 32'h0BADF077);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule